// File: doc/BRIEF.md
# Multi-table complex-gain predistorter

This block pre-shapes a baseband complex sample stream before it reaches a nonlinear power amplifier. It holds four identical gain cells. Each cell picks the input sample at its own programmable delay and estimates that sample's envelope amplitude. The amplitude, quantized uniformly, addresses a 64-entry table of complex gains, and the cell multiplies its delayed sample by the selected gain. The products of all enabled cells are added together, rounded and clamped back to 16-bit I and Q. With parallel cells fed by different delays, the block can model amplifier memory effects as well as a static amplitude-dependent gain.

Each table sits in a two-port memory. One port serves the datapath on every accepted sample. The other port takes coefficient writes from an adaptation engine that runs elsewhere, usually much more slowly, and those writes may land while samples keep streaming. Cells are switched in and out with a per-cell enable. A switched-off cell adds nothing to the sum, so only as many cells are used as the amplifier's memory depth requires. A valid flag travels with the data through a fixed four-cycle pipeline.

Top module: `mlut_predist`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `out_i` and `out_q` are 0 until the first sample comes out.
- R2: A sample accepted with `in_valid` high at a clock edge appears with `out_valid` high after exactly four rising edges, counting that edge. Between output samples, `out_i` and `out_q` keep their last value.
- R3: Each cell forms the amplitude estimate max(|I|,|Q|) + floor(min(|I|,|Q|)/2), with |−32768| first limited to 32767 and the result limited to 32767. Bits 14 down to 9 of that 15-bit amplitude are the table address.
- R4: A cell's product for delayed sample (i,q) and table entry (gi,gq) is (i·gi − q·gq, i·gq + q·gi). Gains are signed 16-bit values with 14 fraction bits, so 16384 means a gain of 1.
- R5: Cell k uses the sample delayed by the 3-bit value in `tap_dly[3k+2:3k]`, counted in accepted samples. A value of 0 selects the current input sample. The history is zero after reset.
- R6: When `cell_en[k]` is 0 at the time a sample is accepted, cell k contributes zero to that sample's output.
- R7: The output I (and Q) is the sum of the products, plus 8192, shifted arithmetically right by 14, that is, rounded half toward positive infinity.
- R8: A rounded sum above 32767 gives 32767 and one below −32768 gives −32768, with no wraparound.
- R9: A write with `wr_en` high stores (`wr_gi`,`wr_gq`) at entry `wr_addr` of the table of cell `wr_cell`, even while samples stream.
- R10: A datapath read of the same entry on the same edge as a write returns the old value. Reads from the next edge onward see the new value.
- R11: The delay history advances only on edges where `in_valid` is high. Idle cycles do not shift it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_i | input | 16 | Input I, signed |
| in_q | input | 16 | Input Q, signed |
| cell_en | input | 4 | Per-cell enable |
| tap_dly | input | 12 | Per-cell delay, 3 bits per cell, cell 0 in the low bits |
| wr_en | input | 1 | Table write strobe |
| wr_cell | input | 2 | Cell whose table is written |
| wr_addr | input | 6 | Table entry written |
| wr_gi | input | 16 | Gain real part, Q2.14 |
| wr_gq | input | 16 | Gain imaginary part, Q2.14 |
| out_valid | output | 1 | Output sample valid |
| out_i | output | 16 | Predistorted I, signed |
| out_q | output | 16 | Predistorted Q, signed |

## Verification
The main function is driven with several distinct patterns. A unity table passes samples through unchanged, including full-scale corners. A ramp table gives every entry a distinct gain, so a wrong address bit or a wrong amplitude estimate shows up as a wrong output. Small rotating gains exercise the cross terms and rounding toward both signs. Four cells with distinct delays and gains are fed a sequence broken by idle gaps, which separates a wrong tap, a history that shifts on idle cycles and a wrong sign in a cross term. Enable masks, sums driven past full scale in both directions, and a table write that lands on the same edge as the read of that entry cover R6, R8, R9 and R10.

// File: rtl/mlut_pkg.sv
package mlut_pkg;
    localparam int SMP_W   = 16;  // I/Q sample width
    localparam int GAIN_W  = 16;  // gain word width
    localparam int GAIN_FR = 14;  // gain fraction bits
    localparam int TBL_AW  = 6;   // table address width
    localparam int N_CELL  = 4;
    localparam int DLY_W   = 3;   // per-cell delay select width
endpackage

// File: rtl/mlut_delay_line.sv
module mlut_delay_line #(
    parameter int DW    = 16,
    parameter int NCELL = 4,
    parameter int TAPW  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_vld,
    input  logic [DW-1:0]               in_i,
    input  logic [DW-1:0]               in_q,
    input  logic [NCELL*TAPW-1:0]       tap_dly,
    output logic [NCELL-1:0][DW-1:0]    tap_i,
    output logic [NCELL-1:0][DW-1:0]    tap_q
);
    localparam int NTAP = 1 << TAPW;

    logic [DW-1:0] h_i [1:NTAP-1];
    logic [DW-1:0] h_q [1:NTAP-1];
    logic [DW-1:0] ch_i [0:NTAP-1];
    logic [DW-1:0] ch_q [0:NTAP-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 1; k < NTAP; k++) begin
                h_i[k] <= '0;
                h_q[k] <= '0;
            end
        end else if (in_vld) begin
            h_i[1] <= in_i;
            h_q[1] <= in_q;
            for (int k = 2; k < NTAP; k++) begin
                h_i[k] <= h_i[k-1];
                h_q[k] <= h_q[k-1];
            end
        end
    end

    assign ch_i[0] = in_i;
    assign ch_q[0] = in_q;
    for (genvar k = 1; k < NTAP; k++) begin : g_chain
        assign ch_i[k] = h_i[k];
        assign ch_q[k] = h_q[k];
    end

    for (genvar c = 0; c < NCELL; c++) begin : g_tap
        assign tap_i[c] = ch_i[tap_dly[c*TAPW +: TAPW]];
        assign tap_q[c] = ch_q[tap_dly[c*TAPW +: TAPW]];
    end

    // R11: history frozen on idle cycles
    p_hist_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(h_i[1]) && $stable(h_q[1]) && $stable(h_i[NTAP-1])));
endmodule

// File: rtl/mlut_cell.sv
module mlut_cell #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int AW = 6,
    localparam int PW = DW + CW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [DW-1:0]        smp_i,
    input  logic [DW-1:0]        smp_q,
    input  logic                 en,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [CW-1:0]        wr_gi,
    input  logic [CW-1:0]        wr_gq,
    output logic                 prod_vld,
    output logic signed [PW-1:0] prod_i,
    output logic signed [PW-1:0] prod_q
);
    localparam int DEPTH = 1 << AW;
    localparam logic [DW:0] LIM = (DW+1)'((1 << (DW-1)) - 1);

    function automatic logic [DW:0] abs_lim(input logic [DW-1:0] v);
        logic signed [DW:0] s;
        logic [DW:0]        a;
        s = {v[DW-1], v};
        a = s[DW] ? (DW+1)'(-s) : (DW+1)'(s);
        return (a > LIM) ? LIM : a;
    endfunction

    // amplitude estimate and table address
    logic [DW:0]   ai, aq, mx, mn, mg;
    logic [AW-1:0] addr;
    always_comb begin
        ai = abs_lim(smp_i);
        aq = abs_lim(smp_q);
        mx = (ai >= aq) ? ai : aq;
        mn = (ai >= aq) ? aq : ai;
        mg = mx + (mn >> 1);
        if (mg > LIM) mg = LIM;
        addr = mg[DW-2 -: AW];
    end

    // stage A: registered sample and address
    logic                 a_v, a_en;
    logic [DW-1:0]        a_i, a_q;
    logic [AW-1:0]        a_addr;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_v <= 1'b0; a_en <= 1'b0; a_i <= '0; a_q <= '0; a_addr <= '0;
        end else begin
            a_v <= in_vld;
            if (in_vld) begin
                a_i <= smp_i; a_q <= smp_q; a_addr <= addr; a_en <= en;
            end
        end
    end

    // gain table: write port and read port, read returns pre-write data
    logic [2*CW-1:0] mem [DEPTH];
    logic [2*CW-1:0] rd;
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= {wr_gi, wr_gq};
        if (a_v)   rd <= mem[a_addr];
    end

    // stage B: sample aligned with the table read
    logic                 b_v, b_en;
    logic signed [DW-1:0] b_i, b_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_v <= 1'b0; b_en <= 1'b0; b_i <= '0; b_q <= '0;
        end else begin
            b_v <= a_v;
            if (a_v) begin
                b_i <= a_i; b_q <= a_q; b_en <= a_en;
            end
        end
    end

    // stage C: complex multiply
    logic signed [CW-1:0]    g_i, g_q;
    logic signed [DW+CW-1:0] m_ii, m_qq, m_iq, m_qi;
    logic signed [PW-1:0]    c_re, c_im;
    always_comb begin
        g_i  = rd[2*CW-1:CW];
        g_q  = rd[CW-1:0];
        m_ii = b_i * g_i;
        m_qq = b_q * g_q;
        m_iq = b_i * g_q;
        m_qi = b_q * g_i;
        c_re = PW'(m_ii) - PW'(m_qq);
        c_im = PW'(m_iq) + PW'(m_qi);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_vld <= 1'b0; prod_i <= '0; prod_q <= '0;
        end else begin
            prod_vld <= b_v;
            if (b_v) begin
                prod_i <= b_en ? c_re : '0;
                prod_q <= b_en ? c_im : '0;
            end
        end
    end

    // R6: a switched-off cell feeds zero into the sum
    p_off_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_v && !b_en) |=> (prod_i == '0 && prod_q == '0));
endmodule

// File: rtl/mlut_sum.sv
module mlut_sum #(
    parameter int DW    = 16,
    parameter int PW    = 33,
    parameter int NCELL = 4,
    parameter int FRAC  = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld,
    input  logic [NCELL-1:0][PW-1:0] prod_i,
    input  logic [NCELL-1:0][PW-1:0] prod_q,
    output logic                     out_valid,
    output logic [DW-1:0]            out_i,
    output logic [DW-1:0]            out_q
);
    localparam int SW = PW + $clog2(NCELL) + 1;
    localparam logic signed [SW-1:0] HALF = SW'(1) << (FRAC - 1);
    localparam logic signed [SW-1:0] HMAX = SW'((1 << (DW-1)) - 1);
    localparam logic signed [SW-1:0] HMIN = -HMAX - SW'(1);

    function automatic logic [DW-1:0] rnd_sat(input logic signed [SW-1:0] s);
        logic signed [SW-1:0] r;
        r = (s + HALF) >>> FRAC;
        if (r > HMAX)      return HMAX[DW-1:0];
        else if (r < HMIN) return HMIN[DW-1:0];
        else               return r[DW-1:0];
    endfunction

    logic signed [SW-1:0] acc_i, acc_q;
    always_comb begin
        acc_i = '0;
        acc_q = '0;
        for (int k = 0; k < NCELL; k++) begin
            acc_i = acc_i + SW'($signed(prod_i[k]));
            acc_q = acc_q + SW'($signed(prod_q[k]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_i <= '0; out_q <= '0;
        end else begin
            out_valid <= vld;
            if (vld) begin
                out_i <= rnd_sat(acc_i);
                out_q <= rnd_sat(acc_q);
            end
        end
    end

    // R2: outputs hold between samples
    p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> ($stable(out_i) && $stable(out_q)));
endmodule

// File: rtl/mlut_predist.sv
module mlut_predist
    import mlut_pkg::*;
#(
    parameter int DW    = SMP_W,
    parameter int CW    = GAIN_W,
    parameter int FRAC  = GAIN_FR,
    parameter int AW    = TBL_AW,
    parameter int NCELL = N_CELL,
    parameter int TAPW  = DLY_W,
    localparam int SELW = (NCELL > 1) ? $clog2(NCELL) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [DW-1:0]         in_i,
    input  logic [DW-1:0]         in_q,
    input  logic [NCELL-1:0]      cell_en,
    input  logic [NCELL*TAPW-1:0] tap_dly,
    input  logic                  wr_en,
    input  logic [SELW-1:0]       wr_cell,
    input  logic [AW-1:0]         wr_addr,
    input  logic [CW-1:0]         wr_gi,
    input  logic [CW-1:0]         wr_gq,
    output logic                  out_valid,
    output logic [DW-1:0]         out_i,
    output logic [DW-1:0]         out_q
);
    localparam int PW = DW + CW + 1;

    logic [NCELL-1:0][DW-1:0] tap_i, tap_q;
    logic [NCELL-1:0][PW-1:0] pr_i, pr_q;
    logic [NCELL-1:0]         pr_v;

    mlut_delay_line #(.DW(DW), .NCELL(NCELL), .TAPW(TAPW)) u_dly (
        .clk(clk), .rst_n(rst_n), .in_vld(in_valid), .in_i(in_i), .in_q(in_q),
        .tap_dly(tap_dly), .tap_i(tap_i), .tap_q(tap_q)
    );

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        mlut_cell #(.DW(DW), .CW(CW), .AW(AW)) u_cell (
            .clk(clk), .rst_n(rst_n), .in_vld(in_valid),
            .smp_i(tap_i[k]), .smp_q(tap_q[k]), .en(cell_en[k]),
            .wr_en(wr_en && (wr_cell == SELW'(k))), .wr_addr(wr_addr),
            .wr_gi(wr_gi), .wr_gq(wr_gq),
            .prod_vld(pr_v[k]), .prod_i(pr_i[k]), .prod_q(pr_q[k])
        );
    end

    mlut_sum #(.DW(DW), .PW(PW), .NCELL(NCELL), .FRAC(FRAC)) u_sum (
        .clk(clk), .rst_n(rst_n), .vld(pr_v[0]), .prod_i(pr_i), .prod_q(pr_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // R2: fixed latency, checked once four edges have passed since reset
    logic [2:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= '0;
        else if (warm != 3'd4) warm <= warm + 3'd1;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    p_cells_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_v == '0) || (pr_v == '1));
endmodule

// File: tb/mlut_predist_bench.sv
module mlut_predist_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0, in_q = '0;
    logic [3:0]  cell_en = '0;
    logic [11:0] tap_dly = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_cell = '0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_gi = '0, wr_gq = '0;
    logic        out_valid;
    logic [15:0] out_i, out_q;

    always #5 clk = ~clk;

    mlut_predist u_mlut_predist (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cell_en(cell_en), .tap_dly(tap_dly), .wr_en(wr_en), .wr_cell(wr_cell),
        .wr_addr(wr_addr), .wr_gi(wr_gi), .wr_gq(wr_gq),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int total = 0;
    int bad = 0;
    int ref_gi [4][64];
    int ref_gq [4][64];
    int mh_i [8];
    int mh_q [8];
    int cap_i [$];
    int cap_q [$];
    int exp_i [$];
    int exp_q [$];

    always @(negedge clk) begin
        if (out_valid) begin
            cap_i.push_back(int'($signed(out_i)));
            cap_q.push_back(int'($signed(out_q)));
        end
    end

    task automatic chk(input string req, input string what, input int act, input int expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int lim15(input int v);
        int a;
        a = (v < 0) ? -v : v;
        return (a > 32767) ? 32767 : a;
    endfunction

    function automatic int amp_addr(input int i, input int q);   // R3
        int a, b, mx, mn, m;
        a = lim15(i); b = lim15(q);
        mx = (a >= b) ? a : b;
        mn = (a >= b) ? b : a;
        m = mx + mn / 2;
        if (m > 32767) m = 32767;
        return m >> 9;
    endfunction

    function automatic int rsat(input longint s);               // R7, R8
        longint r;
        r = (s + 64'sd8192) >>> 14;
        if (r > 32767)  return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_gain(input int c, input int a, input int gi, input int gq);
        wr_en = 1'b1; wr_cell = 2'(c); wr_addr = 6'(a);
        wr_gi = 16'(gi); wr_gq = 16'(gq);
        @(negedge clk);
        wr_en = 1'b0;
        ref_gi[c][a] = gi;
        ref_gq[c][a] = gq;
    endtask

    task automatic fill(input int c, input int gi, input int gq);
        for (int a = 0; a < 64; a++) wr_gain(c, a, gi, gq);
    endtask

    task automatic push(input int xi, input int xq);
        longint si, sq;
        int d, ti, tq, ad;
        si = 0; sq = 0;
        for (int c = 0; c < 4; c++) begin
            d = int'(tap_dly[c*3 +: 3]);
            ti = (d == 0) ? xi : mh_i[d];
            tq = (d == 0) ? xq : mh_q[d];
            ad = amp_addr(ti, tq);
            if (cell_en[c]) begin
                si += longint'(ti) * ref_gi[c][ad] - longint'(tq) * ref_gq[c][ad];
                sq += longint'(ti) * ref_gq[c][ad] + longint'(tq) * ref_gi[c][ad];
            end
        end
        exp_i.push_back(rsat(si));
        exp_q.push_back(rsat(sq));
        for (int k = 7; k > 1; k--) begin
            mh_i[k] = mh_i[k-1];
            mh_q[k] = mh_q[k-1];
        end
        mh_i[1] = xi; mh_q[1] = xq;
        in_valid = 1'b1; in_i = 16'(xi); in_q = 16'(xq);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        idle(8);
        chk(req, "sample count", cap_i.size(), exp_i.size());
        for (int k = 0; k < exp_i.size() && k < cap_i.size(); k++) begin
            chk(req, $sformatf("I[%0d]", k), cap_i[k], exp_i[k]);
            chk(req, $sformatf("Q[%0d]", k), cap_q[k], exp_q[k]);
        end
        cap_i.delete(); cap_q.delete(); exp_i.delete(); exp_q.delete();
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        idle(2);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "out_i after reset", int'(out_i), 0);
        chk("R1", "out_q after reset", int'(out_q), 0);
    endtask

    task automatic t_unity;        // R4 pass-through, R9 table load
        tap_dly = '0; cell_en = 4'b0001;
        fill(0, 16384, 0);
        push(1000, -2000);
        push(32767, -32768);
        push(-32768, -32768);
        push(0, 0);
        push(12345, -321);
        drain("R4");
    endtask

    task automatic t_latency;      // R2
        int seen;
        seen = 0;
        in_valid = 1'b1; in_i = 16'd77; in_q = 16'd0;
        mh_i[1] = 0;
        for (int n = 1; n <= 6; n++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (out_valid && seen == 0) seen = n;
        end
        for (int k = 7; k > 1; k--) begin mh_i[k] = mh_i[k-1]; mh_q[k] = mh_q[k-1]; end
        mh_i[1] = 77; mh_q[1] = 0;
        chk("R2", "edges to out_valid", seen, 4);
        chk("R2", "latency sample value", int'($signed(out_i)), 77);
        idle(3);
        chk("R2", "output held while idle", int'($signed(out_i)), 77);
        cap_i.delete(); cap_q.delete();
    endtask

    task automatic t_addr;         // R3
        for (int a = 0; a < 64; a++) wr_gain(0, a, 1000 + 250 * a, -40 * a);
        push(0, 0);
        push(511, 0);
        push(512, 0);
        push(-32768, 0);
        push(20000, 20000);
        push(30000, -30000);
        push(-100, -7000);
        push(3000, -1100);
        push(-18000, 9000);
        drain("R3");
    endtask

    task automatic t_round;        // R7, R4 cross terms
        fill(0, 8192, 0);
        push(1, 0);
        push(-1, 0);
        push(3, -3);
        drain("R7");
        fill(0, 11585, -11585);
        push(3, 0);
        push(-3, 0);
        push(1200, -700);
        push(-25000, 31000);
        drain("R4");
    endtask

    task automatic t_delay;        // R5, R11
        fill(0, 16384, 0);
        fill(1, -4096, 2048);
        fill(2, 2048, -1024);
        fill(3, 1024, 512);
        cell_en = 4'b1111;
        tap_dly = {3'd7, 3'd3, 3'd1, 3'd0};
        for (int k = 0; k < 14; k++) begin
            push(1500 * k - 9000, 700 - 400 * k);
            if (k % 3 == 1) idle(3);
        end
        drain("R5");
        push(4444, -2222);
        idle(5);
        push(-300, 600);
        drain("R11");
    endtask

    task automatic t_enable;       // R6
        cell_en = 4'b0101;
        push(5000, 1000); push(-2000, 3000);
        drain("R6");
        cell_en = 4'b1000;
        push(100, 200); push(-7000, 0);
        drain("R6");
        cell_en = 4'b0000;
        push(20000, -20000);
        drain("R6");
    endtask

    task automatic t_sat;          // R8
        tap_dly = '0; cell_en = 4'b1111;
        for (int c = 0; c < 4; c++) fill(c, 32767, 0);
        push(30000, -30000);
        push(-30000, 30000);
        push(4000, 0);
        drain("R8");
        fill(0, 32767, 32767);
        push(20000, 20000);
        drain("R8");
    endtask

    task automatic t_collision;    // R10, R9
        cell_en = 4'b0001; tap_dly = '0;
        fill(0, 16384, 0);
        push(8000, 0);             // entry 15 read on the next edge
        wr_gain(0, 15, 4096, 0);   // write lands on that same edge
        push(8000, 0);             // new gain seen from here on
        drain("R10");
        push(9000, 0);
        wr_gain(1, 17, 0, 0);      // other cell written while streaming
        push(8800, 0);
        drain("R9");
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog run did not finish actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) begin mh_i[k] = 0; mh_q[k] = 0; end
        t_reset();
        for (int c = 0; c < 4; c++) fill(c, 0, 0);
        t_unity();
        t_latency();
        t_addr();
        t_round();
        t_delay();
        t_enable();
        t_sat();
        t_collision();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule